// File: doc/BRIEF.md
# Scan Load/Unload Translator for an Inverting Feed-Forward Scan Chain

A tester-side helper for a scan chain whose flops are linked by inverters and forward XOR taps. Such a chain still behaves like a plain shift register when seen only from its serial pins, but the bits it shows are scrambled. The translator is built with the same inversion and tap parameters as the chain it serves. It hides the scrambling in both directions.

For a **load**, the controller gives a K-bit target state and pulses start. The translator then sends K serial bits, one per clock, each with a valid strobe. Those K bits, shifted into the chain, leave exactly the target state in it, whatever the chain held before. For an **unload**, the controller shifts the chain K times with scan-in held at 0 and feeds each scan-out bit to the translator. The translator returns the state the chain held before the first shift.

Both mappings are affine over GF(2). At elaboration the translator runs the chain symbolically to get two triangular coefficient sets. At run time it solves them by back-substitution.

Top module: `scan_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, ld_busy, ld_valid, ld_done and ul_done are 0 and ul_state is all zeros.
- R2: A ld_start seen while ld_busy is 0 is accepted at that clock edge. From the next cycle on, ld_busy and ld_valid are 1 for exactly K consecutive cycles.
- R3: ld_done is 1 for exactly one cycle: the cycle right after the last ld_valid cycle.
- R4: If ld_bit is fed into the chain's scan-in on each ld_valid cycle, in the order sent, the chain holds the requested ld_target when ld_done is seen. This holds for any state the chain had before.
- R5: A ld_start that arrives while ld_busy is 1 is ignored. The running load still finishes with its own target, and no second load follows it.
- R6: After the K-th cycle with ul_valid at 1, ul_done pulses for one cycle in the next cycle. ul_state then equals the chain state from before the first shift. The k-th accepted ul_bit is the chain's scan-out before the k-th shift, and the chain's scan-in is held at 0 during the unload.
- R7: Cycles with ul_valid at 0 are not counted and do not change the decode. Gaps between unload bits give the same result as back-to-back bits.
- R8: ul_state holds its value in every cycle without ul_done. This includes a whole load run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_start | input | 1 | Request a load of ld_target |
| ld_target | input | K | Desired chain state, bit i is flop i (flop 0 nearest scan-in) |
| ld_busy | output | 1 | Load sequence in progress |
| ld_valid | output | 1 | ld_bit is to be shifted into the chain this cycle |
| ld_bit | output | 1 | Serial scan-in value |
| ld_done | output | 1 | One-cycle pulse after the last load bit |
| ul_valid | input | 1 | ul_bit is a scan-out sample, and the chain shifts this cycle |
| ul_bit | input | 1 | Chain scan-out (last flop) before the shift |
| ul_done | output | 1 | One-cycle pulse when ul_state is updated |
| ul_state | output | K | Decoded chain state from before the unload |

## Verification
Suppose a coefficient, an inversion constant or the order of the held load sequence is wrong. The chain then ends a load in a state different from the target. This shows at the chain's parallel outputs in the cycle ld_done rises, K+1 cycles after the request. A wrong unload count or decode shows as a ul_done that comes early, late or with the wrong value. The monitor compares each one against the captured state, so the error appears the cycle after the K-th accepted bit. Every tap pattern differs in both directions, so the bench runs many random states through a chain that has several taps and mixed inversions.

// File: rtl/scan_xlate_pkg.sv
package scan_xlate_pkg;

    // Counter width for a count of n states, never below one bit.
    function automatic int ctr_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/scr_chain.sv
// Scrambled scan chain: inversions and forward XOR taps between flops.
// TAPS bit j*K+i set means flop i feeds flop j during shift (i < j-1 only).
module scr_chain #(
    parameter int                 K    = 8,
    parameter logic [K*K-1:0]     TAPS = 64'h0210_0400_0100_0000,
    parameter logic [K-1:0]       INV  = 8'b1010_0110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         scan_in,
    input  logic         cap_en,
    input  logic [K-1:0] cap_data,
    output logic [K-1:0] state,
    output logic         scan_out
);

    logic [K-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d = cap_data;
        end else if (shift_en) begin
            st_d[0] = scan_in ^ INV[0];
            for (int j = 1; j < K; j++) begin
                logic acc;
                acc = st_q[j-1] ^ INV[j];
                for (int i = 0; i < j - 1; i++) begin
                    if (TAPS[j*K+i]) acc = acc ^ st_q[i];
                end
                st_d[j] = acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state    = st_q;
    assign scan_out = st_q[K-1];

endmodule

// File: rtl/xl_loader.sv
// Turns a target state into the serial sequence that produces it.
// FORMS holds K affine rows of K+1 bits: row j gives final flop j as a
// function of input bits x0..x(K-1) (bit m) plus a constant (bit K).
module xl_loader
    import scan_xlate_pkg::*;
#(
    parameter int                   K     = 8,
    parameter logic [K*(K+1)-1:0]   FORMS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [K-1:0] target,
    output logic         busy,
    output logic         valid,
    output logic         bit_o,
    output logic         done
);

    localparam int CW = ctr_w(K);
    localparam logic [CW-1:0] LAST = CW'(K - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [K-1:0]  seq;
    } ld_state_t;

    ld_state_t s_d, s_q;
    logic [K-1:0] seq_sol;

    // Back-substitution: row j has unit weight on x(K-1-j) and otherwise
    // only on later inputs, so rows are solved in ascending order.
    always_comb begin
        seq_sol = '0;
        for (int j = 0; j < K; j++) begin
            logic acc;
            acc = target[j] ^ FORMS[j*(K+1)+K];
            for (int m = 0; m < K; m++) begin
                if (m != K - 1 - j && FORMS[j*(K+1)+m]) acc = acc ^ seq_sol[m];
            end
            seq_sol[K-1-j] = acc;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.seq = s_q.seq >> 1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.seq  = seq_sol;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign valid = s_q.busy;
    assign bit_o = s_q.seq[0];
    assign done  = s_q.done;

endmodule

// File: rtl/xl_unloader.sv
// Collects K scan-out samples and recovers the state held before shifting.
// FORMS row m gives sample m as a function of initial flops (bit i) plus
// a constant (bit K); row m has unit weight on flop K-1-m, else lower flops.
module xl_unloader
    import scan_xlate_pkg::*;
#(
    parameter int                   K     = 8,
    parameter logic [K*(K+1)-1:0]   FORMS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         bit_i,
    output logic         done,
    output logic [K-1:0] state
);

    localparam int CW = ctr_w(K);
    localparam logic [CW-1:0] LAST = CW'(K - 1);

    typedef struct packed {
        logic          done;
        logic [CW-1:0] cnt;
        logic [K-1:0]  smp;
        logic [K-1:0]  res;
    } ul_state_t;

    ul_state_t s_d, s_q;
    logic [K-1:0] smp_nx;
    logic [K-1:0] dec;

    assign smp_nx = {bit_i, s_q.smp[K-1:1]};

    // Solve from flop 0 upward (last sample first).
    always_comb begin
        dec = '0;
        for (int m = K - 1; m >= 0; m--) begin
            logic acc;
            acc = smp_nx[m] ^ FORMS[m*(K+1)+K];
            for (int i = 0; i < K; i++) begin
                if (i != K - 1 - m && FORMS[m*(K+1)+i]) acc = acc ^ dec[i];
            end
            dec[K-1-m] = acc;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (valid) begin
            s_d.smp = smp_nx;
            if (s_q.cnt == LAST) begin
                s_d.res  = dec;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done  = s_q.done;
    assign state = s_q.res;

endmodule

// File: rtl/scan_xlate.sv
module scan_xlate #(
    parameter int                 K    = 8,
    parameter logic [K*K-1:0]     TAPS = 64'h0210_0400_0100_0000,
    parameter logic [K-1:0]       INV  = 8'b1010_0110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_start,
    input  logic [K-1:0] ld_target,
    output logic         ld_busy,
    output logic         ld_valid,
    output logic         ld_bit,
    output logic         ld_done,
    input  logic         ul_valid,
    input  logic         ul_bit,
    output logic         ul_done,
    output logic [K-1:0] ul_state
);

    typedef logic [K:0]        form_t;
    typedef form_t [K-1:0]     mat_t;

    // One symbolic shift step on affine forms, scan-in given as a form.
    function automatic mat_t sym_step(input mat_t cur, input form_t xin);
        mat_t nx;
        nx[0]    = xin;
        nx[0][K] = nx[0][K] ^ INV[0];
        for (int j = 1; j < K; j++) begin
            nx[j] = cur[j-1];
            for (int i = 0; i < j - 1; i++) begin
                if (TAPS[j*K+i]) nx[j] = nx[j] ^ cur[i];
            end
            nx[j][K] = nx[j][K] ^ INV[j];
        end
        return nx;
    endfunction

    // Final state after K shifts, in terms of the K inputs.
    function automatic mat_t load_forms();
        mat_t cur;
        cur = '0;
        for (int c = 0; c < K; c++) cur = sym_step(cur, form_t'(1) << c);
        return cur;
    endfunction

    // Scan-out samples in terms of the initial state, scan-in at 0.
    function automatic mat_t obs_forms();
        mat_t cur, res;
        for (int i = 0; i < K; i++) cur[i] = form_t'(1) << i;
        for (int m = 0; m < K; m++) begin
            res[m] = cur[K-1];
            cur    = sym_step(cur, '0);
        end
        return res;
    endfunction

    localparam mat_t LD_FORMS = load_forms();
    localparam mat_t UL_FORMS = obs_forms();

    xl_loader #(.K(K), .FORMS(LD_FORMS)) i_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ld_start),
        .target (ld_target),
        .busy   (ld_busy),
        .valid  (ld_valid),
        .bit_o  (ld_bit),
        .done   (ld_done)
    );

    xl_unloader #(.K(K), .FORMS(UL_FORMS)) i_unloader (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (ul_valid),
        .bit_i  (ul_bit),
        .done   (ul_done),
        .state  (ul_state)
    );

endmodule

// File: rtl/scan_xlate_chk.sv
module scan_xlate_chk #(
    parameter int K = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_start,
    input logic         ld_busy,
    input logic         ld_done,
    input logic         ul_valid,
    input logic         ul_done,
    input logic [K-1:0] ul_state
);

    logic [$clog2(K+1):0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (ld_busy) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R2
    start_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start && !ld_busy |=> ld_busy);
    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_busy |-> run_q < ($clog2(K+1)+1)'(K));
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_busy) |-> run_q == ($clog2(K+1)+1)'(K));
    // R3
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> !ld_busy && $past(ld_busy));
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done);
    // R6
    ul_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ul_done |-> $past(ul_valid));
    // R8
    ul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ul_done |-> $stable(ul_state));

endmodule

bind scan_xlate scan_xlate_chk #(.K(K)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_start (ld_start),
    .ld_busy  (ld_busy),
    .ld_done  (ld_done),
    .ul_valid (ul_valid),
    .ul_done  (ul_done),
    .ul_state (ul_state)
);

// File: tb/test_scan_xlate.sv
module test_scan_xlate;

    localparam int K = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_start = 1'b0;
    logic [K-1:0] ld_target = '0;
    logic         ld_busy, ld_valid, ld_bit, ld_done;
    logic         ul_valid = 1'b0;
    logic         ul_done;
    logic [K-1:0] ul_state;
    logic         sh_req = 1'b0;
    logic         cap_en = 1'b0;
    logic [K-1:0] cap_data = '0;
    logic [K-1:0] ch_state;
    logic         ch_out;
    logic         ch_in;
    logic         ch_shift;

    int nvec = 0;
    int nerr = 0;
    logic [K-1:0] exp_q[$];

    always #5 clk = ~clk;

    assign ch_in    = ld_valid ? ld_bit : 1'b0;
    assign ch_shift = ld_valid | sh_req;

    scan_xlate i_scan_xlate (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_target(ld_target),
        .ld_busy(ld_busy), .ld_valid(ld_valid), .ld_bit(ld_bit), .ld_done(ld_done),
        .ul_valid(ul_valid), .ul_bit(ch_out), .ul_done(ul_done), .ul_state(ul_state)
    );

    scr_chain i_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(ch_shift), .scan_in(ch_in),
        .cap_en(cap_en), .cap_data(cap_data), .state(ch_state), .scan_out(ch_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every decode result is compared with the oldest captured state.
    always @(negedge clk) begin
        if (rst_n && ul_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected ul_done", 64'(ul_state), 64'hx);
            end else begin
                logic [K-1:0] e;
                e = exp_q.pop_front();
                chk(ul_state == e, "R6/R7 decoded state", 64'(ul_state), 64'(e));
            end
        end
    end

    task automatic capture(input logic [K-1:0] v);
        @(negedge clk);
        cap_en = 1'b1; cap_data = v;
        @(negedge clk);
        cap_en = 1'b0;
    endtask

    task automatic do_load(input logic [K-1:0] t, input bit again);
        int cnt;
        cnt = 0;
        @(negedge clk);
        ld_start = 1'b1; ld_target = t;
        @(negedge clk);
        ld_start = 1'b0;
        while (ld_valid && cnt < 4*K) begin
            cnt++;
            if (again && cnt == 2) begin ld_start = 1'b1; ld_target = ~t; end
            else ld_start = 1'b0;
            @(negedge clk);
        end
        ld_start = 1'b0;
        chk(cnt == K, "R2 valid run length", 64'(cnt), 64'(K));
        chk(ld_done == 1'b1, "R3 done after last bit", 64'(ld_done), 64'd1);
        chk(ch_state == t, again ? "R5 target kept" : "R4 chain reaches target",
            64'(ch_state), 64'(t));
        @(negedge clk);
        chk(ld_done == 1'b0, "R3 done single cycle", 64'(ld_done), 64'd0);
        chk(ld_busy == 1'b0, "R5 no second run", 64'(ld_busy), 64'd0);
        chk(ch_state == t, "R5 chain unchanged", 64'(ch_state), 64'(t));
    endtask

    task automatic do_unload(input logic [K-1:0] v, input bit gaps);
        capture(v);
        exp_q.push_back(v);
        for (int m = 0; m < K; m++) begin
            sh_req = 1'b1; ul_valid = 1'b1;
            @(negedge clk);
            sh_req = 1'b0; ul_valid = 1'b0;
            if (gaps && m < K - 1) begin
                repeat (1 + (m % 3)) @(negedge clk);
            end
        end
        @(negedge clk);
        chk(exp_q.size() == 0, gaps ? "R7 decode with gaps" : "R6 decode count",
            64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [K-1:0] held;
        repeat (2) @(negedge clk);
        chk({ld_busy, ld_valid, ld_done, ul_done} == 4'b0, "R1 flags in reset",
            64'({ld_busy, ld_valid, ld_done, ul_done}), 64'd0);
        chk(ul_state == '0, "R1 state in reset", 64'(ul_state), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ld_busy, ld_valid, ld_done, ul_done} == 4'b0, "R1 flags after reset",
            64'({ld_busy, ld_valid, ld_done, ul_done}), 64'd0);

        do_load(8'h00, 1'b0);
        do_load(8'hFF, 1'b0);
        capture(8'h5A);
        do_load(8'h01, 1'b0);
        do_load(8'h80, 1'b0);
        for (int n = 0; n < 12; n++) begin
            capture(K'($urandom));
            do_load(K'($urandom), 1'b0);
        end
        capture(8'hC3);
        do_load(8'h3C, 1'b1);
        do_load(K'($urandom), 1'b1);

        do_unload(8'h00, 1'b0);
        do_unload(8'hFF, 1'b0);
        do_unload(8'h80, 1'b0);
        do_unload(8'h01, 1'b1);
        for (int n = 0; n < 12; n++) begin
            do_unload(K'($urandom), n[0]);
        end

        held = ul_state;
        do_load(K'($urandom), 1'b0);
        chk(ul_state == held, "R8 decode held over load", 64'(ul_state), 64'(held));
        repeat (3) @(negedge clk);
        chk(ul_state == held, "R8 decode held idle", 64'(ul_state), 64'(held));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule